// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block is a debug comparator that sits beside a system bus. Each bus cycle comes with a valid strobe and four attributes: which master drives it (CPU or DMA), whether it is an instruction fetch or a data access, its direction, and its operand size. When a cycle matches the programmed break condition, the block raises a single-cycle break request and sets a sticky flag that software reads and clears.

The condition sits in one 16-bit register, reached through a small register read/write port. Four two-bit selectors in its low byte choose the master, the access kind, the direction and the size. A zero in the master, access-kind or direction selector turns break generation off. A zero in the size selector means any size. A second address gives the sticky flag on reads and clears it on writes. Either standby input returns the condition to zero.

Top module: `bus_break_matcher`

## Requirements
- R1: The condition register reads back 16 bits at address 0. Bits 15:8 always read as zero, and writes to them have no effect.
- R2: Bits 7:0 of the condition register read back as last written. Their layout is master select in 7:6, access-kind select in 5:4, direction select in 3:2 and size select in 1:0.
- R3: Master select: 00 never breaks, 01 matches CPU cycles (`cyc_dma`=0), 10 matches DMA cycles (`cyc_dma`=1), 11 matches both.
- R4: Access-kind select: 00 never breaks, 01 matches instruction fetches (`cyc_data`=0), 10 matches data accesses (`cyc_data`=1), 11 matches both.
- R5: Direction select: 00 never breaks, 01 matches reads (`cyc_write`=0), 10 matches writes (`cyc_write`=1), 11 matches both.
- R6: Size select: 00 matches any size. 01, 10 and 11 match only cycles whose `cyc_size` is 01 (byte), 10 (word) or 11 (longword) respectively.
- R7: A break occurs only when one cycle satisfies all four selectors together.
- R8: After power-on reset the condition register is 0x0000, `brk_pulse` is 0 and `brk_flag` is 0.
- R9: While `standby_mod` or `standby_sw` is high, the condition register is forced to 0x0000, overriding any write in the same cycle.
- R10: Matching happens only in cycles where `cyc_valid` is high. Each matching cycle gives `brk_pulse` high for exactly the following clock cycle.
- R11: A match sets `brk_flag`, which stays set until a write of 1 in bit 0 at address 1. A read at address 1 returns the flag in bit 0, with all other bits zero.
- R12: When a clear write and a match fall in the same clock cycle, the match wins and `brk_flag` stays set.
- R13: A condition write takes effect from the next clock cycle. A bus cycle in the same clock as the write is compared against the old condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| standby_mod | input | 1 | Module standby; clears the condition |
| standby_sw | input | 1 | Software standby; clears the condition |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 condition, 1 flag/clear) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| cyc_valid | input | 1 | Bus cycle valid strobe |
| cyc_dma | input | 1 | Master: 0 CPU, 1 DMA |
| cyc_data | input | 1 | Kind: 0 instruction fetch, 1 data access |
| cyc_write | input | 1 | Direction: 0 read, 1 write |
| cyc_size | input | 2 | Size: 01 byte, 10 word, 11 longword |
| brk_pulse | output | 1 | One-cycle break request |
| brk_flag | output | 1 | Sticky break flag |

## Verification
Several properties are checked on every cycle:
- The reserved upper byte always reads zero.
- A break pulse only follows a valid strobe.
- The flag is set whenever a pulse appears.
- The flag falls only after a clear write.
- A standby request silences the pulse two cycles later.

The bench scenarios are needed for the rest:
- The meaning of each selector encoding and the rule that all four must agree.
- The reset contents.
- The priority of a match over a clear.
- The rule that a write is seen only by later bus cycles.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
    localparam int SEL_W = 2;

    typedef struct packed {
        logic [SEL_W-1:0] master;
        logic [SEL_W-1:0] kind;
        logic [SEL_W-1:0] dir;
        logic [SEL_W-1:0] size;
    } bbm_cond_t;

    localparam int COND_W = $bits(bbm_cond_t);

    typedef struct packed {
        logic pulse;
        logic flag;
    } bbm_evt_t;
endpackage

// File: rtl/bbm_regs.sv
module bbm_regs
    import bbm_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              flag_in,
    output bbm_cond_t         cond_o,
    output logic [REG_W-1:0]  rdata_o,
    output logic              clr_o
);
    localparam logic [ADDR_W-1:0] COND_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

    bbm_cond_t cond_d, cond_q;
    logic      unused_hi;

    assign unused_hi = ^reg_wdata[REG_W-1:COND_W];

    always_comb begin
        cond_d = cond_q;
        if (standby)
            cond_d = '0;
        else if (reg_wr && reg_addr == COND_ADDR)
            cond_d = bbm_cond_t'(reg_wdata[COND_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_d;
    end

    always_comb begin
        rdata_o = '0;
        case (reg_addr)
            COND_ADDR: rdata_o[COND_W-1:0] = cond_q;
            STAT_ADDR: rdata_o[0] = flag_in;
            default:   rdata_o = '0;
        endcase
    end

    assign clr_o  = reg_wr && (reg_addr == STAT_ADDR) && reg_wdata[0];
    assign cond_o = cond_q;
endmodule

// File: rtl/bbm_match.sv
module bbm_match
    import bbm_pkg::*;
(
    input  bbm_cond_t        cond,
    input  logic             valid,
    input  logic             is_dma,
    input  logic             is_data,
    input  logic             is_write,
    input  logic [SEL_W-1:0] size,
    output logic             hit
);
    localparam int N_BIN = 3;

    logic [SEL_W-1:0] sel  [N_BIN];
    logic [N_BIN-1:0] attr;
    logic [N_BIN-1:0] field_ok;
    logic             size_ok;

    always_comb begin
        sel[0] = cond.master;
        sel[1] = cond.kind;
        sel[2] = cond.dir;
        attr   = {is_write, is_data, is_dma};
    end

    for (genvar g = 0; g < N_BIN; g++) begin : g_bin
        // bit 0 of a selector accepts attribute value 0, bit 1 accepts value 1
        assign field_ok[g] = (sel[g][0] & ~attr[g]) | (sel[g][1] & attr[g]);
    end

    always_comb begin
        size_ok = (cond.size == '0) || (cond.size == size);
        hit     = valid && (&field_ok) && size_ok;
    end
endmodule

// File: rtl/bbm_event.sv
module bbm_event
    import bbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pulse_o,
    output logic flag_o
);
    bbm_evt_t evt_d, evt_q;

    always_comb begin
        evt_d       = evt_q;
        evt_d.pulse = hit;
        if (hit)      evt_d.flag = 1'b1;
        else if (clr) evt_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign pulse_o = evt_q.pulse;
    assign flag_o  = evt_q.flag;
endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
    import bbm_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_mod,
    input  logic              standby_sw,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cyc_valid,
    input  logic              cyc_dma,
    input  logic              cyc_data,
    input  logic              cyc_write,
    input  logic [1:0]        cyc_size,
    output logic              brk_pulse,
    output logic              brk_flag
);
    bbm_cond_t cond;
    logic      hit;
    logic      clr;
    logic      standby;

    assign standby = standby_mod | standby_sw;

    bbm_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .flag_in  (brk_flag),
        .cond_o   (cond),
        .rdata_o  (reg_rdata),
        .clr_o    (clr)
    );

    bbm_match u_match (
        .cond    (cond),
        .valid   (cyc_valid),
        .is_dma  (cyc_dma),
        .is_data (cyc_data),
        .is_write(cyc_write),
        .size    (cyc_size),
        .hit     (hit)
    );

    bbm_event u_event (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .clr    (clr),
        .pulse_o(brk_pulse),
        .flag_o (brk_flag)
    );
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_mod,
    input logic              standby_sw,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              cyc_valid,
    input logic              brk_pulse,
    input logic              brk_flag
);
    localparam int LOW_W = 8;

    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> (reg_rdata[REG_W-1:LOW_W] == '0));

    assert_pulse_after_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(cyc_valid));

    assert_pulse_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> brk_flag);

    assert_flag_falls_on_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_flag) |-> $past(reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[0]));

    assert_standby_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_mod || standby_sw) |=> ##1 !brk_pulse);
endmodule

bind bus_break_matcher bbm_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby_mod(standby_mod),
    .standby_sw (standby_sw),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cyc_valid  (cyc_valid),
    .brk_pulse  (brk_pulse),
    .brk_flag   (brk_flag)
);

// File: tb/bus_break_matcher_tb_top.sv
`timescale 1ns/1ps
module bus_break_matcher_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_mod = 1'b0, standby_sw = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cyc_valid = 1'b0, cyc_dma = 1'b0, cyc_data = 1'b0, cyc_write = 1'b0;
    logic [1:0]  cyc_size = 2'b00;
    logic        brk_pulse, brk_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    bus_break_matcher dut_i (.*);

    // entry: cond[13:6] dma[5] data[4] write[3] size[2:1] expect[0]
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {8'b01_01_01_00, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1}, // R3 CPU fetch read
        {8'b01_01_01_00, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0}, // R3 DMA rejected
        {8'b10_10_10_10, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1}, // R4 R5 R6 DMA data write word
        {8'b10_10_10_10, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0}, // R7 size alone differs
        {8'b11_11_11_11, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1}, // R3 both masters
        {8'b11_11_11_11, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1}, // R4 both kinds
        {8'b00_11_11_00, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0}, // R3 master off
        {8'b11_00_11_00, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0}, // R4 kind off
        {8'b11_11_00_00, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0}, // R5 direction off
        {8'b11_11_11_01, 1'b1, 1'b1, 1'b0, 2'b01, 1'b1}, // R6 byte
        {8'b11_10_11_00, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0}, // R4 fetch rejected
        {8'b11_11_01_00, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0}  // R5 write rejected
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // drives one valid cycle; on return the resulting pulse is visible
    task automatic bus(input logic d, input logic k, input logic w, input logic [1:0] s);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_dma = d; cyc_data = k; cyc_write = w; cyc_size = s;
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        check(brk_pulse == 1'b0, "R8 pulse", brk_pulse, 0);
        check(brk_flag == 1'b0, "R8 flag", brk_flag, 0);
        rd_check(2'd0, 16'h0000, "R8 cond");

        // R1 R2 reserved bits and low-byte readback
        wr(2'd0, 16'hABCD);
        rd_check(2'd0, 16'h00CD, "R1 R2 readback");

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {8'h00, VEC[i][13:6]});
            wr(2'd1, 16'h0001);
            bus(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2:1]);
            check(brk_pulse == VEC[i][0], $sformatf("R3-7 vector %0d pulse", i), brk_pulse, VEC[i][0]);
            check(brk_flag == VEC[i][0], $sformatf("R11 vector %0d flag", i), brk_flag, VEC[i][0]);
        end

        // R10 valid low does not match; single pulse per match
        wr(2'd0, 16'h00FC);
        wr(2'd1, 16'h0001);
        @(negedge clk);
        cyc_dma = 1'b0; cyc_data = 1'b1; cyc_write = 1'b0; cyc_size = 2'b11;
        @(negedge clk);
        check(brk_pulse == 1'b0, "R10 no valid", brk_pulse, 0);
        bus(1'b0, 1'b1, 1'b0, 2'b11);
        check(brk_pulse == 1'b1, "R10 pulse", brk_pulse, 1);
        @(negedge clk);
        check(brk_pulse == 1'b0, "R10 single pulse", brk_pulse, 0);

        // R11 flag sticky, readable, cleared by write
        repeat (3) @(negedge clk);
        check(brk_flag == 1'b1, "R11 sticky", brk_flag, 1);
        rd_check(2'd1, 16'h0001, "R11 status read");
        wr(2'd1, 16'h0000);
        check(brk_flag == 1'b1, "R11 zero write ignored", brk_flag, 1);
        wr(2'd1, 16'h0001);
        check(brk_flag == 1'b0, "R11 cleared", brk_flag, 0);

        // R12 match beats clear
        bus(1'b1, 1'b0, 1'b1, 2'b01);
        @(negedge clk);
        reg_addr = 2'd1; reg_wdata = 16'h0001; reg_wr = 1'b1;
        cyc_valid = 1'b1; cyc_dma = 1'b0; cyc_data = 1'b0; cyc_write = 1'b0; cyc_size = 2'b10;
        @(negedge clk);
        reg_wr = 1'b0; cyc_valid = 1'b0;
        check(brk_flag == 1'b1, "R12 match wins", brk_flag, 1);

        // R13 same-clock bus cycle uses old condition
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 16'h0000; reg_wr = 1'b1;
        cyc_valid = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; cyc_valid = 1'b0;
        check(brk_pulse == 1'b1, "R13 old condition", brk_pulse, 1);
        bus(1'b0, 1'b0, 1'b0, 2'b10);
        check(brk_pulse == 1'b0, "R13 new condition", brk_pulse, 0);

        // R9 standby clears condition
        wr(2'd0, 16'h00FC);
        @(negedge clk);
        standby_sw = 1'b1;
        @(negedge clk);
        standby_sw = 1'b0;
        rd_check(2'd0, 16'h0000, "R9 soft standby");
        bus(1'b0, 1'b1, 1'b1, 2'b11);
        check(brk_pulse == 1'b0, "R9 no break", brk_pulse, 0);
        @(negedge clk);
        standby_mod = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h00FC; reg_wr = 1'b1;
        @(negedge clk);
        standby_mod = 1'b0; reg_wr = 1'b0;
        rd_check(2'd0, 16'h0000, "R9 module standby beats write");

        finish_up();
    end
endmodule